// File: doc/BRIEF.md
# Clock Source Selection Controller

This block holds the control state that decides where the CPU and peripheral clock comes from. There are three sources: the main clock, a slow internal oscillator, and the output of a PLL multiplier. Software programs the block through a small register port. The block drives the enable pins of the internal oscillator and of the PLL, the PLL multiplier code, and a two-bit source code for an external glitch-free multiplexer. It also routes the watchdog count source and checks the clock state before a wait or stop request is accepted.

The block enforces four rules:
- The PLL is only selectable once a lock counter shows it has been running long enough.
- The multiplier code can be written once after reset.
- When main-clock stop detection is armed in interrupt mode and the main clock stops, the controller moves the system to the internal oscillator on its own.
- A rejected operation, or a refused power-mode request, sets a sticky error bit.

The register port is a plain control interface with no back-pressure. A write completes in the cycle that `wr_en` is sampled. `rdata` follows `addr` combinationally. The request inputs `wait_req` and `stop_req` are single-cycle strobes. Each is answered by a one-cycle acknowledge in the next cycle, or refused without an acknowledge.

Top module: `clksrc_ctrl`

Register map:

| Register | `addr` | Bits |
|---|---|---|
| CTRL | 0 | bit0 oscillator select, bit1 PLL select, bit2 stop-detect enable, bit3 stop-detect interrupt mode, bit4 watchdog-from-oscillator |
| PLLC | 1 | bit0 PLL enable, bits[3:1] multiplier code |
| STAT | 2 | bit0 PLL stable (read-only), bit1 error (write 1 to clear), bit2 fail-over (write 1 to clear), bit3 multiplier locked (read-only) |
| (none) | 3 | reads zero |

## Requirements
- R1: After reset, `osc_en`, `pll_en`, `pll_stable`, `fail_irq`, `wait_ack` and `stop_ack` are 0, `src_sel` is 00 (main clock), and CTRL, PLLC and STAT all read 0.
- R2: The `src_sel` encoding is 00 main, 01 internal oscillator, 10 PLL. Writing CTRL bit0 = 1 while CTRL bit1 is 0 drives `osc_en` = 1 and `src_sel` = 01. Clearing it returns `src_sel` to 00.
- R3: CTRL bit4 = 1 drives `wdt_src_osc` = 1 and `osc_en` = 1 without changing `src_sel`.
- R4: PLLC bit0 drives `pll_en`. `pll_stable` (STAT bit0) is still 0 LOCK_CYCLES−1 cycles after the write edge that set PLLC bit0, and is 1 after LOCK_CYCLES cycles. It drops when PLLC bit0 is cleared.
- R5: A write of CTRL bit1 = 1 is accepted, giving `src_sel` = 10, only when `pll_stable` is 1 and the multiplier code is valid. Otherwise CTRL bit1 stays 0 and STAT bit1 (error) is set.
- R6: The multiplier code is PLLC bits[3:1], with 001 = ×2, 010 = ×4, 011 = ×6 and 100 = ×8, and it appears on `pll_mult`. The first PLLC write stores it and sets STAT bit3. Later PLLC writes leave the code unchanged.
- R7: Codes 000, 101, 110 and 111 are invalid. Storing one sets the error bit, and the PLL then stays unselectable.
- R8: A PLLC write that clears bit0 while CTRL bit1 is 1 is rejected: `pll_en` stays 1 and the error bit is set.
- R9: A `wait_req` strobe gives a one-cycle `wait_ack` in the next cycle if CTRL bit1 is 0. Otherwise it is refused with no acknowledge and the error bit is set.
- R10: A `stop_req` strobe is acknowledged in the next cycle only when CTRL bit1 and PLLC bit0 are both 0. Otherwise it is refused and the error bit is set.
- R11: When CTRL bit2, CTRL bit3 and `main_stopped` are all 1, the next edge does three things:
  - it sets CTRL bit0 and clears CTRL bit1, so `src_sel` becomes 01;
  - it sets STAT bit2;
  - it raises `fail_irq`.
  With either enable bit clear, `main_stopped` has no effect.
- R12: Writing 1 to STAT bit1 or STAT bit2 clears that bit. STAT bit2 is set again at once while the fail-over condition persists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| main_stopped | input | 1 | Main clock stop detected |
| wait_req | input | 1 | Wait-mode entry request strobe |
| stop_req | input | 1 | Stop-mode entry request strobe |
| wait_ack | output | 1 | Wait request accepted (one cycle) |
| stop_ack | output | 1 | Stop request accepted (one cycle) |
| osc_en | output | 1 | Internal oscillator enable |
| pll_en | output | 1 | PLL enable |
| pll_mult | output | 3 | PLL multiplier code |
| pll_stable | output | 1 | PLL lock time has elapsed |
| src_sel | output | 2 | System clock source code |
| wdt_src_osc | output | 1 | Watchdog counts the internal oscillator |
| fail_irq | output | 1 | Fail-over interrupt |

## Verification
A wrong lock count shows up in two ways: `pll_stable` rising one cycle early or late, and a PLL-select write at the boundary cycle being accepted when it should be rejected. The bench therefore probes the cycle just before lock and the cycle of lock. A lost write-once flag shows at once as a changed `pll_mult` after a second PLLC write. A stale select or enable bit shows as a wrong `src_sel` on the edge after the write, or as an acknowledge given to a wait or stop request that should have been refused. A missed fail-over shows as `src_sel` still at 10 on the edge after `main_stopped` rises.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int MULT_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_PLLC = 2'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd2;

  // CTRL field positions
  localparam int C_OSC  = 0;
  localparam int C_PSEL = 1;
  localparam int C_DET  = 2;
  localparam int C_DINT = 3;
  localparam int C_WDT  = 4;
  // STAT field positions
  localparam int S_STB  = 0;
  localparam int S_ERR  = 1;
  localparam int S_FO   = 2;
  localparam int S_LCK  = 3;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'b00,
    SRC_IOSC = 2'b01,
    SRC_PLL  = 2'b10
  } src_e;

  function automatic logic mult_ok(input logic [MULT_W-1:0] code);
    return (code != '0) && (code <= 3'd4);
  endfunction
endpackage

// File: rtl/clksrc_lock_timer.sv
module clksrc_lock_timer #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_en,
  output logic pll_stable
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!pll_en)      cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign pll_stable = pll_en && (cnt_q == LIMIT);

  // R4
  stable_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_stable) |-> $past(pll_en));
endmodule

// File: rtl/clksrc_pm_guard.sv
module clksrc_pm_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic stop_req,
  input  logic pll_sel,
  input  logic pll_en,
  output logic wait_ack,
  output logic stop_ack,
  output logic refuse
);
  logic wait_ok, stop_ok;

  always_comb begin
    wait_ok = !pll_sel;
    stop_ok = !pll_sel && !pll_en;
    refuse  = (wait_req && !wait_ok) || (stop_req && !stop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_ack <= 1'b0;
      stop_ack <= 1'b0;
    end else begin
      wait_ack <= wait_req && wait_ok;
      stop_ack <= stop_req && stop_ok;
    end
  end

  // R9
  wait_ack_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_ack |-> $past(!pll_sel));
  // R10
  stop_ack_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ack |-> $past(!pll_sel && !pll_en));
endmodule

// File: rtl/clksrc_regfile.sv
module clksrc_regfile
  import clksrc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              main_stopped,
  input  logic              pll_stable,
  input  logic              pm_refuse,
  output logic              osc_sel,
  output logic              pll_sel,
  output logic              wdt_osc,
  output logic              pll_en,
  output logic [MULT_W-1:0] mult,
  output logic              fo_stat
);
  logic osc_sel_q, pll_sel_q, det_q, dint_q, wdt_q, pll_en_q;
  logic lock_q, err_q, fo_q;
  logic [MULT_W-1:0] mult_q;

  logic osc_sel_d, pll_sel_d, det_d, dint_d, wdt_d, pll_en_d;
  logic lock_d, err_d, fo_d;
  logic [MULT_W-1:0] mult_d;

  logic wr_ctrl, wr_pllc, wr_stat, fo_evt, err_set;

  always_comb begin
    wr_ctrl = wr_en && (addr == A_CTRL);
    wr_pllc = wr_en && (addr == A_PLLC);
    wr_stat = wr_en && (addr == A_STAT);
    fo_evt  = det_q && dint_q && main_stopped;

    osc_sel_d = osc_sel_q;
    pll_sel_d = pll_sel_q;
    det_d     = det_q;
    dint_d    = dint_q;
    wdt_d     = wdt_q;
    pll_en_d  = pll_en_q;
    mult_d    = mult_q;
    lock_d    = lock_q;
    err_set   = pm_refuse;

    if (wr_ctrl) begin
      osc_sel_d = wdata[C_OSC];
      det_d     = wdata[C_DET];
      dint_d    = wdata[C_DINT];
      wdt_d     = wdata[C_WDT];
      if (!wdata[C_PSEL]) begin
        pll_sel_d = 1'b0;
      end else if (!pll_sel_q) begin
        if (pll_stable && mult_ok(mult_q)) pll_sel_d = 1'b1;
        else                               err_set   = 1'b1;
      end
    end

    if (wr_pllc) begin
      if (!wdata[0] && pll_sel_q) err_set  = 1'b1;
      else                        pll_en_d = wdata[0];
      if (!lock_q) begin
        mult_d = wdata[MULT_W:1];
        lock_d = 1'b1;
        if (!mult_ok(wdata[MULT_W:1])) err_set = 1'b1;
      end
    end

    if (fo_evt) begin
      osc_sel_d = 1'b1;
      pll_sel_d = 1'b0;
    end

    err_d = (err_q && !(wr_stat && wdata[S_ERR])) || err_set;
    fo_d  = (fo_q  && !(wr_stat && wdata[S_FO]))  || fo_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_sel_q <= 1'b0;
      pll_sel_q <= 1'b0;
      det_q     <= 1'b0;
      dint_q    <= 1'b0;
      wdt_q     <= 1'b0;
      pll_en_q  <= 1'b0;
      mult_q    <= '0;
      lock_q    <= 1'b0;
      err_q     <= 1'b0;
      fo_q      <= 1'b0;
    end else begin
      osc_sel_q <= osc_sel_d;
      pll_sel_q <= pll_sel_d;
      det_q     <= det_d;
      dint_q    <= dint_d;
      wdt_q     <= wdt_d;
      pll_en_q  <= pll_en_d;
      mult_q    <= mult_d;
      lock_q    <= lock_d;
      err_q     <= err_d;
      fo_q      <= fo_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: begin
        rdata[C_OSC]  = osc_sel_q;
        rdata[C_PSEL] = pll_sel_q;
        rdata[C_DET]  = det_q;
        rdata[C_DINT] = dint_q;
        rdata[C_WDT]  = wdt_q;
      end
      A_PLLC: begin
        rdata[0]        = pll_en_q;
        rdata[MULT_W:1] = mult_q;
      end
      A_STAT: begin
        rdata[S_STB] = pll_stable;
        rdata[S_ERR] = err_q;
        rdata[S_FO]  = fo_q;
        rdata[S_LCK] = lock_q;
      end
      default: rdata = '0;
    endcase
  end

  assign osc_sel = osc_sel_q;
  assign pll_sel = pll_sel_q;
  assign wdt_osc = wdt_q;
  assign pll_en  = pll_en_q;
  assign mult    = mult_q;
  assign fo_stat = fo_q;

  // R5
  psel_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_sel_q) |-> $past(pll_stable) && mult_ok(mult_q));
  // R6
  mult_write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lock_q) |-> $stable(mult_q));
  // R11
  failover_moves_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fo_evt) |-> osc_sel_q && !pll_sel_q && fo_q);
  // R8
  pll_held_while_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pll_sel_q) && $past(pll_sel_q, 2) |-> $past(pll_en_q));
endmodule

// File: rtl/clksrc_ctrl.sv
module clksrc_ctrl
  import clksrc_pkg::*;
#(
  parameter int LOCK_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        main_stopped,
  input  logic        wait_req,
  input  logic        stop_req,
  output logic        wait_ack,
  output logic        stop_ack,
  output logic        osc_en,
  output logic        pll_en,
  output logic [2:0]  pll_mult,
  output logic        pll_stable,
  output logic [1:0]  src_sel,
  output logic        wdt_src_osc,
  output logic        fail_irq
);
  logic osc_sel, pll_sel, wdt_osc, pm_refuse, fo_stat;
  src_e src;

  clksrc_regfile u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .main_stopped(main_stopped),
    .pll_stable  (pll_stable),
    .pm_refuse   (pm_refuse),
    .osc_sel     (osc_sel),
    .pll_sel     (pll_sel),
    .wdt_osc     (wdt_osc),
    .pll_en      (pll_en),
    .mult        (pll_mult),
    .fo_stat     (fo_stat)
  );

  clksrc_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .pll_en    (pll_en),
    .pll_stable(pll_stable)
  );

  clksrc_pm_guard u_pm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wait_req(wait_req),
    .stop_req(stop_req),
    .pll_sel (pll_sel),
    .pll_en  (pll_en),
    .wait_ack(wait_ack),
    .stop_ack(stop_ack),
    .refuse  (pm_refuse)
  );

  always_comb begin
    if (pll_sel)      src = SRC_PLL;
    else if (osc_sel) src = SRC_IOSC;
    else              src = SRC_MAIN;
  end

  assign src_sel     = src;
  assign osc_en      = osc_sel || wdt_osc;
  assign wdt_src_osc = wdt_osc;
  assign fail_irq    = fo_stat;

  // R2
  iosc_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b01) |-> osc_en);
  // R4
  pll_src_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'b10) |-> pll_en);
endmodule

// File: tb/clksrc_ctrl_tb_top.sv
module clksrc_ctrl_tb_top;
  localparam int LOCK = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       main_stopped = 1'b0;
  logic       wait_req = 1'b0;
  logic       stop_req = 1'b0;
  logic       wait_ack, stop_ack, osc_en, pll_en, pll_stable, wdt_src_osc, fail_irq;
  logic [2:0] pll_mult;
  logic [1:0] src_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clksrc_ctrl #(.LOCK_CYCLES(LOCK)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .main_stopped(main_stopped), .wait_req(wait_req),
    .stop_req(stop_req), .wait_ack(wait_ack), .stop_ack(stop_ack),
    .osc_en(osc_en), .pll_en(pll_en), .pll_mult(pll_mult),
    .pll_stable(pll_stable), .src_sel(src_sel), .wdt_src_osc(wdt_src_osc),
    .fail_irq(fail_irq)
  );

  // vector: wdata[19:12] readback[11:4] src[3:2] osc_en[1] wdt[0]
  localparam logic [19:0] VECS [0:3] = '{
    {8'h01, 8'h01, 2'b01, 1'b1, 1'b0},
    {8'h10, 8'h10, 2'b00, 1'b1, 1'b1},
    {8'h0D, 8'h0D, 2'b01, 1'b1, 1'b0},
    {8'h00, 8'h00, 2'b00, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clr_err();
    wr(2'd2, 8'h02);
  endtask

  task automatic strobe(input bit is_stop);
    if (is_stop) stop_req = 1'b1; else wait_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop_req = 1'b0; wait_req = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    check("R1 src", {6'd0, src_sel}, 8'h00);
    check("R1 enables", {4'd0, osc_en, pll_en, pll_stable, fail_irq}, 8'h00);
    check("R1 acks", {6'd0, wait_ack, stop_ack}, 8'h00);
    rd(2'd0, v); check("R1 CTRL", v, 8'h00);
    rd(2'd1, v); check("R1 PLLC", v, 8'h00);
    rd(2'd2, v); check("R1 STAT", v, 8'h00);

    // R2 R3 table walk
    for (int i = 0; i < 4; i++) begin
      wr(2'd0, VECS[i][19:12]);
      rd(2'd0, v); check("R2 CTRL readback", v, VECS[i][11:4]);
      check("R2 src_sel", {6'd0, src_sel}, {6'd0, VECS[i][3:2]});
      check("R3 osc_en/wdt", {6'd0, osc_en, wdt_src_osc}, {6'd0, VECS[i][1:0]});
    end

    // R11 negative: detection enabled without interrupt mode
    wr(2'd0, 8'h04);
    main_stopped = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R11 no failover src", {6'd0, src_sel}, 8'h00);
    check("R11 no failover irq", {7'd0, fail_irq}, 8'h00);
    main_stopped = 1'b0;
    wr(2'd0, 8'h00);

    // R4 R5 R6 lock timing and early select
    wr(2'd1, 8'h03);
    check("R4 pll_en", {7'd0, pll_en}, 8'h01);
    check("R6 pll_mult x2", {5'd0, pll_mult}, 8'h01);
    rd(2'd2, v); check("R6 locked flag", v, 8'h08);
    repeat (LOCK - 2) @(negedge clk);
    wr(2'd0, 8'h02);
    rd(2'd0, v); check("R5 early select rejected", v, 8'h00);
    rd(2'd2, v); check("R4 not stable at LOCK-1", v, 8'h0A);
    @(negedge clk);
    rd(2'd2, v); check("R4 stable at LOCK", v, 8'h0B);

    // R12 clear error
    clr_err();
    rd(2'd2, v); check("R12 err cleared", v, 8'h09);

    // R6 second write ignored for the code
    wr(2'd1, 8'h09);
    rd(2'd1, v); check("R6 write-once", v, 8'h03);
    check("R6 pll_mult kept", {5'd0, pll_mult}, 8'h01);

    // R5 accepted
    wr(2'd0, 8'h02);
    check("R5 src pll", {6'd0, src_sel}, 8'h02);

    // R8 disabling PLL while selected
    wr(2'd1, 8'h00);
    check("R8 pll_en held", {7'd0, pll_en}, 8'h01);
    rd(2'd2, v); check("R8 err", v, 8'h0B);
    clr_err();

    // R9 R10 refusals while PLL selected
    strobe(1'b0);
    check("R9 wait refused", {7'd0, wait_ack}, 8'h00);
    rd(2'd2, v); check("R9 err", v, 8'h0B);
    clr_err();
    strobe(1'b1);
    check("R10 stop refused sel", {7'd0, stop_ack}, 8'h00);
    clr_err();

    // R9 accepted after deselect
    wr(2'd0, 8'h00);
    check("R2 back to main", {6'd0, src_sel}, 8'h00);
    strobe(1'b0);
    check("R9 wait ack", {7'd0, wait_ack}, 8'h01);
    @(negedge clk);
    check("R9 ack one cycle", {7'd0, wait_ack}, 8'h00);
    strobe(1'b1);
    check("R10 stop refused pll_en", {7'd0, stop_ack}, 8'h00);
    rd(2'd2, v); check("R10 err", v, 8'h0B);
    clr_err();
    wr(2'd1, 8'h00);
    rd(2'd2, v); check("R4 stable drops", v, 8'h08);
    strobe(1'b1);
    check("R10 stop ack", {7'd0, stop_ack}, 8'h01);

    // R11 R12 fail-over from PLL
    wr(2'd1, 8'h01);
    repeat (LOCK) @(negedge clk);
    wr(2'd0, 8'h0E);
    check("R11 pre src pll", {6'd0, src_sel}, 8'h02);
    main_stopped = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R11 src osc", {6'd0, src_sel}, 8'h01);
    check("R11 irq", {7'd0, fail_irq}, 8'h01);
    rd(2'd0, v); check("R11 CTRL", v, 8'h0D);
    wr(2'd2, 8'h04);
    check("R12 fo re-set", {7'd0, fail_irq}, 8'h01);
    main_stopped = 1'b0;
    wr(2'd2, 8'h04);
    check("R12 fo cleared", {7'd0, fail_irq}, 8'h00);

    // R7 invalid code
    do_reset();
    wr(2'd1, 8'h0B);
    rd(2'd2, v); check("R7 invalid code err", v, 8'h0A);
    clr_err();
    repeat (LOCK) @(negedge clk);
    rd(2'd2, v); check("R7 stable", v, 8'h09);
    wr(2'd0, 8'h02);
    check("R7 select blocked", {6'd0, src_sel}, 8'h00);
    rd(2'd2, v); check("R7 err again", v, 8'h0B);

    done = 1'b1;
    report();
  end
endmodule